// File: doc/BRIEF.md
# Auto-Increment Register File Target on a Two-Wire Serial Bus

This block is a target device on a two-wire serial bus (I2C) with one fixed 7-bit device address. It holds a register file of `2**PTR_W` bytes behind a single internal pointer. The pointer survives from one transaction to the next. A write transaction uses its first byte to set the pointer, and every later byte goes to the register the pointer selects. A read transaction sends bytes starting at the pointer. The read may come after a repeated START that follows a pointer write, or it may stand alone as a current-address read. In both cases a burst picks up where the previous access stopped.

The bus lines are sampled with the system clock. Each line passes a two-flop synchronizer and a stability filter before START and STOP conditions and SCL edges are decoded. The block pulls SDA low by raising `sda_oe`, and an external open-drain pad carries that to the bus. There is no byte stream towards the system side, so every pin here is a plain control or line pin and no valid/ready handshake exists. The block never stretches the clock and ignores the general-call address.

Top module: `i2c_regfile_slave`

## Requirements
- R1: Only the address byte whose upper seven bits equal `DEV_ADDR` is acknowledged. Any other address gets no ACK, SDA stays released for the rest of that transaction, and no register or pointer changes.
- R2: In a write transaction, the first byte after the address (R/W bit 0) loads the pointer from its low `PTR_W` bits, so bit 7 is ignored when `PTR_W` is 7. The byte is acknowledged.
- R3: Every later byte in a write transaction is acknowledged and stored at the pointer, and the pointer then advances by one. No extra byte is rejected.
- R4: After an address with R/W bit 1, bytes are sent MSB first from the register at the pointer, and the burst continues for as long as the controller ACKs.
- R5: The pointer persists across STOP. A read with no preceding pointer write starts at the current pointer.
- R6: The pointer advances after every byte sent, whether the controller ACKs or NACKs it. A 6-byte burst from 0x3B leaves the pointer at 0x41.
- R7: Advancing from the last register (`2**PTR_W - 1`) wraps the pointer to 0x00, for both reads and writes.
- R8: After a controller NACK, SDA is released and further SCL pulses are ignored until START or STOP. STOP always releases SDA.
- R9: A repeated START restarts address matching and releases SDA, but it keeps the pointer.
- R10: After reset the pointer is 0x00, all registers are 0x00 and SDA is released.
- R11: `sda_oe` changes only after a detected falling edge of SCL or a START/STOP, never during an SCL-high data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level seen at the pad |
| sda_i | input | 1 | SDA line level seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest situation to reach is a controller that keeps clocking after it has NACKed a read byte. The target must then stay silent and leave the pointer alone, even though SCL edges keep arriving in the middle of what looks like a byte. The bench NACKs a byte, clocks out a further nine bits without a START and expects them to read back as 0xFF. It then issues a standalone current-address read, which shows that the pointer moved by exactly one. Pointer wrap is reached the same way: the pointer is set to the last register with a write that carries no data, so the read that follows crosses the end.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // bus free or not addressed
    ST_ADDR,  // shifting in the address byte
    ST_ACK,   // ACK slot (own or controller's) in progress
    ST_WR,    // shifting in a written byte
    ST_RD,    // shifting out a read byte
    ST_RACK,  // waiting for the controller's ACK/NACK bit
    ST_WAIT   // silent until START or STOP
  } slv_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  // two-flop synchronizer, then a level must persist FILT cycles to pass
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      clean <= 1'b1;
      cnt   <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == clean) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT - 1)) begin
        clean <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  // SDA edges while SCL stays high are bus conditions
  assign start_ev = scl && scl_d && sda_d && !sda;
  assign stop_ev  = scl && scl_d && !sda_d && sda;
  assign scl_rise = scl && !scl_d;
  assign scl_fall = !scl && scl_d;
endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  localparam int DEPTH = 1 << PTR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h42,
  parameter int         PTR_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_in,
  input  logic [7:0]       rdata,
  output logic             sda_oe,
  output logic [PTR_W-1:0] ptr,
  output logic             we,
  output logic [7:0]       wdata
);
  slv_state_e state;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       rw;
  logic       first;

  wire byte_in_done = scl_fall && (cnt == 4'd8);

  assign we    = (state == ST_WR) && byte_in_done && !first && !start_ev && !stop_ev;
  assign wdata = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      rw     <= 1'b0;
      first  <= 1'b0;
      sda_oe <= 1'b0;
      ptr    <= '0;
    end else if (start_ev) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WR: begin
          if (scl_rise && cnt != 4'd8) begin
            shreg <= {shreg[6:0], sda_in};
            cnt   <= cnt + 1'b1;
          end else if (byte_in_done) begin
            cnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                first  <= 1'b1;
                state  <= ST_ACK;
              end else begin
                state <= ST_WAIT;
              end
            end else begin
              sda_oe <= 1'b1;
              state  <= ST_ACK;
              if (first) begin
                ptr   <= shreg[PTR_W-1:0];
                first <= 1'b0;
              end else begin
                ptr <= ptr + 1'b1;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              state  <= ST_RD;
              shreg  <= rdata;
              sda_oe <= ~rdata[7];
            end else begin
              state  <= ST_WR;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
              ptr    <= ptr + 1'b1;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              cnt    <= cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) state <= sda_in ? ST_WAIT : ST_ACK;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h42,
  parameter int         PTR_W    = 7,
  parameter int         FILT     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic [1:0]       raw_lines, clean_lines;
  logic             start_ev, stop_ev, scl_rise, scl_fall;
  logic [PTR_W-1:0] ptr;
  logic             we;
  logic [7:0]       wdata, rdata;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(.FILT(FILT)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_lines[g]),
      .clean (clean_lines[g])
    );
  end

  i2c_bus_events u_ev (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (clean_lines[1]),
    .sda      (clean_lines[0]),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_in   (clean_lines[0]),
    .rdata    (rdata),
    .sda_oe   (sda_oe),
    .ptr      (ptr),
    .we       (we),
    .wdata    (wdata)
  );

  i2c_reg_array #(.PTR_W(PTR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .addr  (ptr),
    .wdata (wdata),
    .rdata (rdata)
  );
endmodule

// File: rtl/i2c_regfile_slave_chk.sv
module i2c_regfile_slave_chk #(
  parameter int PTR_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             scl_fall,
  input logic             start_ev,
  input logic             stop_ev,
  input logic [PTR_W-1:0] ptr,
  input logic             we
);
  assert_release_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe)
    else $error("SDA still driven after STOP");

  assert_release_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe)
    else $error("SDA still driven after START");

  assert_sda_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev))
    else $error("SDA drive changed outside an SCL-low window");

  assert_ptr_moves_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> $past(scl_fall))
    else $error("pointer changed without an SCL falling edge");

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ptr == PTR_W'($past(ptr) + 1'b1))
    else $error("pointer did not step by one after a register write");
endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .scl_fall (scl_fall),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .ptr      (ptr),
  .we       (we)
);

// File: tb/i2c_regfile_slave_bench.sv
module i2c_regfile_slave_bench;
  localparam int Q = 20;                 // clk cycles per quarter SCL period
  localparam logic [7:0] AW = 8'h84;     // 7'h42, write
  localparam logic [7:0] AR = 8'h85;     // 7'h42, read

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int hi_toggles = 0;
  bit finished = 0;
  logic prev_oe = 1'b0;
  logic [7:0] rd_val;
  event rd_ev;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  i2c_regfile_slave u_i2c_regfile_slave (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (m_scl),
    .sda_i  (sda_bus),
    .sda_oe (sda_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R11: drive must not move while SCL is high
  always @(posedge clk) begin
    if (rst_n && m_scl && (sda_oe != prev_oe)) hi_toggles++;
    prev_oe <= sda_oe;
  end

  // scoreboard monitor
  initial forever begin
    @(rd_ev);
    if (exp_q.size() == 0) begin
      chk(0, "scoreboard underrun", rd_val, 0);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rd_val == e, t, rd_val, e);
    end
  end

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; m_sda = 1'b0; wq; m_scl = 1'b0; wq;
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wq; m_scl = 1'b1; wq; m_sda = 1'b1; wq;
  endtask

  task automatic clk_bit(input bit b, output bit s);
    m_sda = b; wq; m_scl = 1'b1; wq; s = sda_bus; wq; m_scl = 1'b0; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    chk(s == !exp_ack, tag, s, !exp_ack);
  endtask

  task automatic expect_rd(input logic [7:0] d, input string tag);
    exp_q.push_back(d);
    tag_q.push_back(tag);
  endtask

  task automatic read_byte(input bit mack);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      rd_val[i] = s;
    end
    ->rd_ev;
    clk_bit(!mack, s);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_bus == 1'b1, "R10 SDA released after reset", sda_bus, 1);

    // R10: pointer 0, registers 0
    i2c_start; send_byte(AR, 1, "R10 address ack");
    expect_rd(8'h00, "R10 reset register content"); read_byte(0); i2c_stop;

    // R2/R3: pointer 0x3B, eight data bytes
    i2c_start; send_byte(AW, 1, "R2 address ack"); send_byte(8'h3B, 1, "R2 pointer byte ack");
    for (int k = 0; k < 8; k++) send_byte(8'h10 + 8'(k), 1, "R3 data byte ack");
    i2c_stop;

    // R2 bit 7 of pointer byte ignored, R9 read after repeated START
    i2c_start; send_byte(AW, 1, "R2 address ack"); send_byte(8'hBB, 1, "R2 pointer ack");
    i2c_start; send_byte(AR, 1, "R9 address ack after Sr");
    expect_rd(8'h10, "R2 pointer low bits only"); read_byte(0); i2c_stop;

    // R4/R6: 6-byte burst from 0x3B
    i2c_start; send_byte(AW, 1, "R4 address ack"); send_byte(8'h3B, 1, "R4 pointer ack");
    i2c_start; send_byte(AR, 1, "R4 read address ack");
    for (int k = 0; k < 6; k++) begin
      expect_rd(8'h10 + 8'(k), "R4 burst byte");
      read_byte(k < 5);
    end
    i2c_stop;

    // R5/R6: standalone read continues at 0x41
    i2c_start; send_byte(AR, 1, "R5 address ack");
    expect_rd(8'h16, "R6 pointer at 0x41 after burst"); read_byte(1);
    expect_rd(8'h17, "R5 current-address continue"); read_byte(0);
    i2c_stop;

    // R9: data write then Sr keeps pointer
    i2c_start; send_byte(AW, 1, "R9 address ack"); send_byte(8'h3E, 1, "R9 pointer ack");
    send_byte(8'h77, 1, "R9 data ack");
    i2c_start; send_byte(AR, 1, "R9 read address ack");
    expect_rd(8'h14, "R9 pointer kept across Sr"); read_byte(0); i2c_stop;

    // R7: wrap on write and read
    i2c_start; send_byte(AW, 1, "R7 address ack"); send_byte(8'h7F, 1, "R7 pointer ack");
    send_byte(8'hA5, 1, "R7 data ack"); send_byte(8'h5A, 1, "R7 wrapped data ack"); i2c_stop;
    i2c_start; send_byte(AW, 1, "R7 address ack"); send_byte(8'h7F, 1, "R7 pointer ack"); i2c_stop;
    i2c_start; send_byte(AR, 1, "R7 read address ack");
    expect_rd(8'hA5, "R7 last register"); read_byte(1);
    expect_rd(8'h5A, "R7 wrapped to register 0"); read_byte(0); i2c_stop;

    // R1: foreign address ignored
    i2c_start; send_byte(8'h26, 0, "R1 foreign write address nack");
    send_byte(8'h00, 0, "R1 foreign byte nack"); send_byte(8'h99, 0, "R1 foreign byte nack");
    i2c_stop;
    i2c_start; send_byte(8'h27, 0, "R1 foreign read address nack");
    expect_rd(8'hFF, "R1 SDA idle on foreign read"); read_byte(0); i2c_stop;
    i2c_start; send_byte(AW, 1, "R1 address ack"); send_byte(8'h00, 1, "R1 pointer ack");
    i2c_start; send_byte(AR, 1, "R1 read address ack");
    expect_rd(8'h5A, "R1 register 0 untouched"); read_byte(0); i2c_stop;

    // R8: NACK then extra clocks are ignored
    i2c_start; send_byte(AW, 1, "R8 address ack"); send_byte(8'h3B, 1, "R8 pointer ack");
    i2c_start; send_byte(AR, 1, "R8 read address ack");
    expect_rd(8'h10, "R8 byte before NACK"); read_byte(0);
    expect_rd(8'hFF, "R8 SDA released after NACK"); read_byte(0);
    i2c_stop;
    i2c_start; send_byte(AR, 1, "R8 address ack");
    expect_rd(8'h11, "R6 pointer moved once after NACKed byte"); read_byte(0); i2c_stop;

    repeat (4 * Q) @(negedge clk);
    chk(hi_toggles == 0, "R11 SDA drive changed while SCL high", hi_toggles, 0);
    chk(exp_q.size() == 0, "scoreboard left items", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule